// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block sits between a processor load port and a burst-capable memory read bus. Each load that arrives while the block is idle starts a four-beat fill of one line of four 64-bit words. The bus delivers the requested word as the first beat, and that word goes back to the load port in the same cycle it arrives. The other three words of the line follow in the same burst. Every beat is written into a one-line buffer.

While a fill is running, the block can hold one more load in a single pending slot, and it treats that load according to its line. A load to a different line is chained: its burst is requested in the cycle right after the current burst's last beat, with no idle cycle on the bus. A load to the line being filled is not served early. It waits for all four beats, then waits a fixed penalty. After that its word is returned from the line buffer.

Addresses are byte addresses. Bits [2:0] select a byte within a word, bits [4:3] give the word index within the line, and the bits above give the line address. Every idle load is treated as a miss. The block has no tag lookup, no replacement and no write path.

Top module: `lfb_fill_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready_o is 1, and rsp_valid_o and bus_start_o are 0.
- R2: A load accepted while idle produces a one-cycle bus_start_o pulse in the next cycle. That pulse carries bus_line_o = address bits [31:5] and bus_word_o = address bits [4:3].
- R3: rsp_valid_o is raised in the same cycle as the first beat of the load's burst, and rsp_data_o then equals that beat's data.
- R4: Beat k of a burst is stored as word (critical index + k) mod 4 of the line. A later same-line read returns the word it names, which shows that the wrap-around order is honoured.
- R5: A load to the line being filled, accepted during its fill, gives no response and no new burst before the last beat. Its response comes exactly PENALTY_CYCLES + 1 cycles after the cycle of the last beat, with the named word of the line.
- R6: A load to a different line, accepted during a fill, makes bus_start_o pulse in the cycle right after the last beat. It carries that load's line and word index, and its critical word is returned with its first beat.
- R7: The pending slot holds one load. req_ready_o is 0 while the slot is full, and also in the cycle in which a burst's last beat arrives.
- R8: Every accepted load gets exactly one response, and responses come in acceptance order.
- R9: A bus beat that arrives while no fill is active is ignored: it causes no response and no bus request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Load request can be accepted |
| req_addr_i | input | 32 | Load byte address |
| rsp_valid_o | output | 1 | Load response pulse |
| rsp_data_o | output | 64 | Load response word |
| bus_start_o | output | 1 | Burst request strobe, one cycle |
| bus_line_o | output | 27 | Line address of the requested burst |
| bus_word_o | output | 2 | Critical word index, delivered as the first beat |
| bus_beat_valid_i | input | 1 | Burst beat valid |
| bus_beat_data_i | input | 64 | Burst beat data |

## Verification
The hard part is getting a second load accepted while a burst is in flight, and then telling the same-line case apart from the different-line case by cycle count alone. The bench bus model stretches the time between the start strobe and the first beat. The driver waits until it sees the strobe, then issues the second load, so that load always lands in the pending slot before the last beat. Same-line pairs use several critical indices, so the word read back from the buffer exposes any error in the wrap-around placement. A third load queued behind a full slot checks both the ready backpressure and back-to-back chaining.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_START   = 2'd1,
    ST_BURST   = 2'd2,
    ST_PENALTY = 2'd3
  } lfb_state_e;
endpackage

// File: rtl/lfb_beat_ctr.sv
module lfb_beat_ctr #(
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned IDX_W = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             beat_i,
  input  logic [IDX_W-1:0] crit_idx_i,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  localparam logic [IDX_W-1:0] CNT_MAX = IDX_W'(LINE_WORDS - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (beat_i) cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + IDX_W'(1);
  end

  assign first_o  = (cnt_q == '0);
  assign last_o   = (cnt_q == CNT_MAX);
  // wrap-around placement: beat k lands at crit + k (line size is a power of two)
  assign wr_idx_o = crit_idx_i + cnt_q;

  assert_beat_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && last_o && !clr_i) |=> first_o);
endmodule

// File: rtl/lfb_line_buf.sv
module lfb_line_buf #(
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned DATA_W     = 64,
  localparam int unsigned IDX_W = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] word_q [LINE_WORDS];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_idx_i == IDX_W'(w))) word_q[w] <= wr_data_i;
    end
  end

  assign rd_data_o = word_q[rd_idx_i];
endmodule

// File: rtl/lfb_req_slot.sv
module lfb_req_slot #(
  parameter int unsigned W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         clr_i,
  input  logic [W-1:0] din_i,
  input  logic         same_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o,
  output logic         same_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
      same_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      dout_o  <= din_i;
      same_o  <= same_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_no_overwrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clr_i) |=> (valid_o && $stable(dout_o)));
endmodule

// File: rtl/lfb_penalty_timer.sv
module lfb_penalty_timer #(
  parameter int unsigned PENALTY_CYCLES = 4,
  localparam int unsigned PW = (PENALTY_CYCLES > 0) ? $clog2(PENALTY_CYCLES + 1) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + PW'(1);
  end

  assign done_o = run_i && (cnt_q == PW'(PENALTY_CYCLES));

  assert_penalty_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= PW'(PENALTY_CYCLES)));
endmodule

// File: rtl/lfb_fill_buffer.sv
module lfb_fill_buffer
  import lfb_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 64,
  parameter int unsigned LINE_WORDS     = 4,
  parameter int unsigned PENALTY_CYCLES = 4,
  localparam int unsigned OFF_W  = $clog2(DATA_W / 8),
  localparam int unsigned IDX_W  = $clog2(LINE_WORDS),
  localparam int unsigned LINE_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              bus_start_o,
  output logic [LINE_W-1:0] bus_line_o,
  output logic [IDX_W-1:0]  bus_word_o,
  input  logic              bus_beat_valid_i,
  input  logic [DATA_W-1:0] bus_beat_data_i
);
  localparam int unsigned SLOT_W = LINE_W + IDX_W;

  lfb_state_e state_q, state_d;
  logic [LINE_W-1:0] act_line_q;
  logic [IDX_W-1:0]  act_idx_q;

  logic [LINE_W-1:0] req_line;
  logic [IDX_W-1:0]  req_idx;
  logic              accept, beat_in, first_beat, last_beat;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] buf_rd;
  logic              pend_v, pend_same, pend_load, pend_clr;
  logic [SLOT_W-1:0] pend_q;
  logic              pen_done, act_from_req, act_from_pend;

  assign req_line = req_addr_i[ADDR_W-1 -: LINE_W];
  assign req_idx  = req_addr_i[OFF_W +: IDX_W];
  assign accept   = req_valid_i && req_ready_o;
  assign beat_in  = (state_q == ST_BURST) && bus_beat_valid_i;

  // one slot; closed during the last beat so the end-of-burst decision sees a settled slot
  assign req_ready_o = (state_q == ST_IDLE) ||
                       (((state_q == ST_START) || (state_q == ST_BURST)) &&
                        !pend_v && !(beat_in && last_beat));

  always_comb begin
    state_d       = state_q;
    act_from_req  = 1'b0;
    act_from_pend = 1'b0;
    pend_clr      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d      = ST_START;
        act_from_req = 1'b1;
      end
      ST_START: state_d = ST_BURST;
      ST_BURST: if (beat_in && last_beat) begin
        if (pend_v && !pend_same) begin
          state_d       = ST_START;
          act_from_pend = 1'b1;
          pend_clr      = 1'b1;
        end else if (pend_v) begin
          state_d = ST_PENALTY;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PENALTY: if (pen_done) begin
        state_d  = ST_IDLE;
        pend_clr = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      act_line_q <= '0;
      act_idx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (act_from_req) begin
        act_line_q <= req_line;
        act_idx_q  <= req_idx;
      end else if (act_from_pend) begin
        act_line_q <= pend_q[SLOT_W-1 -: LINE_W];
        act_idx_q  <= pend_q[IDX_W-1:0];
      end
    end
  end

  assign pend_load = accept && ((state_q == ST_START) || (state_q == ST_BURST));

  lfb_req_slot #(.W(SLOT_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pend_load),
    .clr_i   (pend_clr),
    .din_i   ({req_line, req_idx}),
    .same_i  (req_line == act_line_q),
    .valid_o (pend_v),
    .dout_o  (pend_q),
    .same_o  (pend_same)
  );

  lfb_beat_ctr #(.LINE_WORDS(LINE_WORDS)) u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_START),
    .beat_i     (beat_in),
    .crit_idx_i (act_idx_q),
    .first_o    (first_beat),
    .last_o     (last_beat),
    .wr_idx_o   (wr_idx)
  );

  lfb_line_buf #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .we_i      (beat_in),
    .wr_idx_i  (wr_idx),
    .wr_data_i (bus_beat_data_i),
    .rd_idx_i  (pend_q[IDX_W-1:0]),
    .rd_data_o (buf_rd)
  );

  lfb_penalty_timer #(.PENALTY_CYCLES(PENALTY_CYCLES)) u_pen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_PENALTY),
    .done_o (pen_done)
  );

  assign bus_start_o = (state_q == ST_START);
  assign bus_line_o  = act_line_q;
  assign bus_word_o  = act_idx_q;
  assign rsp_valid_o = (beat_in && first_beat) || ((state_q == ST_PENALTY) && pen_done);
  assign rsp_data_o  = (state_q == ST_PENALTY) ? buf_rd : bus_beat_data_i;

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |=> !bus_start_o);
  assert_idle_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && req_valid_i && req_ready_o) |=> (bus_start_o && (bus_line_o == $past(req_line))));
  assert_chain_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_in && last_beat && pend_v && !pend_same) |=> bus_start_o);
  assert_same_line_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_in && last_beat && pend_v && pend_same) |=> (!rsp_valid_o || (PENALTY_CYCLES == 0)));
  assert_no_idle_beat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && bus_beat_valid_i) |-> !rsp_valid_o);
endmodule

// File: tb/lfb_fill_buffer_tb_top.sv
`timescale 1ns/1ps
module lfb_fill_buffer_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_v, req_ready;
  logic [31:0] req_a;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        bus_start;
  logic [26:0] bus_line;
  logic [1:0]  bus_word;
  logic        mdl_v, stray_v;
  logic [63:0] mdl_d, stray_d;
  logic        beat_v;
  logic [63:0] beat_d;

  assign beat_v = mdl_v | stray_v;
  assign beat_d = stray_v ? stray_d : mdl_d;

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  lfb_fill_buffer #(.PENALTY_CYCLES(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_ready_o(req_ready), .req_addr_i(req_a),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .bus_start_o(bus_start), .bus_line_o(bus_line), .bus_word_o(bus_word),
    .bus_beat_valid_i(beat_v), .bus_beat_data_i(beat_d)
  );

  int checks = 0, errors = 0;
  int start_cyc[64], first_cyc[64], last_cyc[64], start_line[64], start_word[64];
  int nstart = 0, nrsp = 0, npush = 0;
  int rsp_cyc[64];
  int gap = 0;
  bit lastbeat_ready_bad = 0;
  logic [63:0] exp_q[$];

  function automatic logic [63:0] pat(int line, int w);
    return 64'hC0DE_0000_0000_0000 | (64'(line) << 8) | 64'(w);
  endfunction

  function automatic logic [31:0] mk(int line, int w);
    return (32'(line) << 5) | (32'(w) << 3);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus model: wrap-around beats after an optional latency
  initial begin
    mdl_v = 1'b0;
    mdl_d = '0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_start) begin
        int b, ln, wd;
        b = nstart; ln = int'(bus_line); wd = int'(bus_word);
        start_cyc[b] = cyc; start_line[b] = ln; start_word[b] = wd;
        nstart++;
        @(posedge clk);
        repeat (gap) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
          if (k > 0) @(posedge clk);
          #1;
          mdl_v = 1'b1;
          mdl_d = pat(ln, (wd + k) % 4);
          if (k == 0) first_cyc[b] = cyc;
          if (k == 3) last_cyc[b] = cyc;
        end
        @(negedge clk);
        if (req_ready) lastbeat_ready_bad = 1;
        @(posedge clk);
        #1 mdl_v = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        logic [63:0] e;
        rsp_cyc[nrsp] = cyc;
        nrsp++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", rsp_data, 64'h0);
        else begin
          e = exp_q.pop_front();
          chk(rsp_data == e, "R8/R4 response data", rsp_data, e);
        end
      end
    end
  end

  task automatic send(int line, int w, output int acc);
    @(posedge clk); #1;
    req_v = 1'b1;
    req_a = mk(line, w);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    acc = cyc;
    exp_q.push_back(pat(line, w));
    npush++;
    @(posedge clk); #1 req_v = 1'b0;
  endtask

  task automatic wait_rsp(int n);
    while (nrsp < n) @(negedge clk);
  endtask

  task automatic wait_start(int b);
    while (nstart <= b) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int acc, b, n0;
    rst_n = 1'b0; req_v = 1'b0; req_a = '0; stray_v = 1'b0; stray_d = '0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !bus_start, "R1 in reset", {rsp_valid, bus_start, req_ready}, 64'h1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !bus_start, "R1 after reset", {rsp_valid, bus_start, req_ready}, 64'h1);

    // R9: stray beat while idle
    @(posedge clk); #1 stray_v = 1'b1; stray_d = 64'hDEAD;
    @(negedge clk);
    chk(!rsp_valid && !bus_start, "R9 idle beat ignored", {rsp_valid, bus_start}, 64'h0);
    @(posedge clk); #1 stray_v = 1'b0;

    // R2/R3: single miss
    b = nstart; n0 = nrsp;
    send(10, 2, acc);
    wait_rsp(n0 + 1);
    chk(start_cyc[b] == acc + 1, "R2 start cycle", start_cyc[b], acc + 1);
    chk(start_line[b] == 10 && start_word[b] == 2, "R2 start line/word", {start_line[b], start_word[b]}, {32'd10, 32'd2});
    chk(rsp_cyc[n0] == first_cyc[b], "R3 critical same cycle", rsp_cyc[n0], first_cyc[b]);

    // R3: each critical index, varied latency
    for (int w = 0; w < 4; w++) begin
      gap = w;
      b = nstart; n0 = nrsp;
      send(20 + w, w, acc);
      wait_rsp(n0 + 1);
      chk(rsp_cyc[n0] == first_cyc[b], "R3 critical same cycle", rsp_cyc[n0], first_cyc[b]);
      chk(start_word[b] == w, "R2 critical index on bus", start_word[b], w);
    end

    // R4/R5: same-line request during fill
    gap = 3;
    for (int t = 0; t < 4; t++) begin
      int ln, c, s;
      ln = 30 + t;
      c = (t == 0) ? 1 : (t == 1) ? 0 : (t == 2) ? 3 : 2;
      s = (t == 0) ? 3 : (t == 1) ? 0 : (t == 2) ? 2 : 1;
      b = nstart; n0 = nrsp;
      send(ln, c, acc);
      wait_start(b);
      send(ln, s, acc);
      wait_rsp(n0 + 2);
      chk(rsp_cyc[n0 + 1] == last_cyc[b] + P + 1, "R5 penalty timing", rsp_cyc[n0 + 1], last_cyc[b] + P + 1);
      chk(nstart == b + 1, "R5 no extra burst", nstart, b + 1);
    end

    // R6: different-line request chained
    gap = 2;
    b = nstart; n0 = nrsp;
    send(40, 0, acc);
    wait_start(b);
    send(41, 2, acc);
    wait_rsp(n0 + 2);
    chk(start_cyc[b + 1] == last_cyc[b] + 1, "R6 back-to-back start", start_cyc[b + 1], last_cyc[b] + 1);
    chk(start_line[b + 1] == 41 && start_word[b + 1] == 2, "R6 chained line/word", {start_line[b + 1], start_word[b + 1]}, {32'd41, 32'd2});
    chk(rsp_cyc[n0 + 1] == first_cyc[b + 1], "R6 chained critical word", rsp_cyc[n0 + 1], first_cyc[b + 1]);

    // R7: slot full backpressure, then a third request
    gap = 3;
    b = nstart; n0 = nrsp;
    send(50, 1, acc);
    wait_start(b);
    send(51, 3, acc);
    @(negedge clk);
    chk(!req_ready, "R7 ready low with slot full", req_ready, 1'b0);
    send(52, 0, acc);
    wait_rsp(n0 + 3);
    chk(start_cyc[b + 2] == last_cyc[b + 1] + 1, "R7 third request chained", start_cyc[b + 2], last_cyc[b + 1] + 1);
    chk(!lastbeat_ready_bad, "R7 ready low on last beat", lastbeat_ready_bad, 1'b0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && nrsp == npush, "R8 one response per request", nrsp, npush);
    summary();
    $finish;
  end
endmodule